// File: doc/BRIEF.md
# Prescaled Phase-Frequency Detector

This block compares a reference clock against the feedback clock of a voltage-controlled crystal oscillator. It drives UP and DOWN pulses into an external loop filter. A fast sampling clock oversamples both clocks. Each input then goes through its own copy of one divide-by-N prescaler. The detector therefore compares edges at a rate N times lower than the input rate. A lower compare rate gives a wider linear phase range, so the detector tolerates heavy input jitter, but the loop locks more slowly.

The detector itself has two set/clear flags. A rising edge of the divided reference sets UP, and a rising edge of the divided feedback sets DOWN. When both flags are high, a shared clear fires after a programmable number of sampling cycles. That delay sets the minimum pulse width on both outputs, which removes the dead zone for small phase errors. A longer setting than needed only raises the chance of a wrong decision.

The input clocks must run below a quarter of the sampling clock rate. The divide ratio is taken from `div_sel` on the first sampling edge after reset is released, and it stays fixed until the next reset.

Top module: `pfd_prescaled`

## Requirements
- R1: `div_sel` selects the divide ratio N: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16. `ref_div` has a period of N input periods and is high for exactly N/2 input periods.
- R2: `fb_div` is produced by an identical prescaler running at the same ratio, so its period and duty match those of `ref_div`.
- R3: The ratio is latched from `div_sel` on the first sampling edge after `rst_n` rises. Later changes to `div_sel` leave the divided period unchanged until the next reset.
- R4: UP rises only after a rising edge of the divided reference, and DOWN rises only after a rising edge of the divided feedback. When one divided edge leads the other by k sampling cycles, the leading output is high for k+d+1 cycles and the lagging output is high for d+1 cycles, where d is `rst_dly`.
- R5: Once both outputs are high, they clear together after d+1 sampling cycles. A setting of 0 clears them on the next sampling edge.
- R6: Divided edges that land on the same sampling cycle give equal pulses of d+1 cycles on both UP and DOWN.
- R7: UP and DOWN are never both high for more than d+2 consecutive sampling cycles.
- R8: Asserting `rst_n` low clears UP, DOWN, both divided clocks and both prescaler counters at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ref_in | input | 1 | Reference clock, oversampled |
| fb_in | input | 1 | Oscillator feedback clock, oversampled |
| div_sel | input | 2 | Prescaler ratio select, latched after reset |
| rst_dly | input | 3 | Detector clear delay in sampling cycles (0 to 7) |
| up | output | 1 | Pulse when the reference leads |
| dn | output | 1 | Pulse when the feedback leads |
| ref_div | output | 1 | Divided reference clock |
| fb_div | output | 1 | Divided feedback clock |

## Verification
The hardest case to reach from the ports is a controlled phase offset of a few sampling cycles between the two divided edges, including exact coincidence. This case matters because it is where the dead-zone pulse and the overlap limit show up. The stimulus drives both inputs as square waves of the same period, with one of them started k sampling cycles late. Both prescalers start from the same reset, so the offset carries over exactly to the divided edges. The sweep covers every ratio, offsets of 0, 1 and 2 in both directions, and all eight delay settings. Each expected pulse width is computed as k+d+1 or d+1.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int SEL_W = 2;
  localparam int CNT_W = (1 << SEL_W) - 1;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // Terminal count of one half-period: N/2-1 with N = 2^(sel+1).
  function automatic cnt_t half_minus1(input sel_t s);
    half_minus1 = cnt_t'((32'd1 << s) - 32'd1);
  endfunction
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pfd_prescaler.sv
module pfd_prescaler
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  cnt_t half_m1,
  input  logic edge_in,
  output logic dclk,
  output logic rise
);
  cnt_t cnt;
  logic wrap;

  assign wrap = run & edge_in & (cnt == half_m1);
  assign rise = wrap & ~dclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      dclk <= 1'b0;
    end else if (run && edge_in) begin
      if (wrap) begin
        cnt  <= '0;
        dclk <= ~dclk;
      end else begin
        cnt <= cnt + cnt_t'(1);
      end
    end
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= half_m1);

  assert_toggle_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dclk) |-> $past(edge_in));
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_up,
  input  logic             set_dn,
  input  logic [DLY_W-1:0] dly,
  output logic             up,
  output logic             dn
);
  logic [DLY_W-1:0] dcnt;
  logic             both;
  logic             clr;

  assign both = up & dn;
  assign clr  = both & (dcnt == dly);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up   <= 1'b0;
      dn   <= 1'b0;
      dcnt <= '0;
    end else begin
      up   <= (up & ~clr) | set_up;
      dn   <= (dn & ~clr) | set_dn;
      dcnt <= (clr || !both) ? '0 : dcnt + 1'b1;
    end
  end

  // Independent overlap counter for the bound check.
  logic [DLY_W:0] ov_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ov_cnt <= '0;
    else if (both) ov_cnt <= ov_cnt + 1'b1;
    else           ov_cnt <= '0;
  end

  assert_overlap_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ov_cnt <= ({1'b0, dly} + 1'b1));

  assert_up_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up) |-> $past(set_up));

  assert_dn_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn) |-> $past(set_dn));
endmodule

// File: rtl/pfd_prescaled.sv
module pfd_prescaled
  import pfd_pkg::*;
#(
  parameter int DLY_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [DLY_W-1:0] rst_dly,
  output logic             up,
  output logic             dn,
  output logic             ref_div,
  output logic             fb_div
);
  localparam int NCH = 2;

  logic armed;
  sel_t ratio_q;
  cnt_t half_m1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      ratio_q <= '0;
    end else if (!armed) begin
      armed   <= 1'b1;
      ratio_q <= div_sel;
    end
  end

  assign half_m1 = half_minus1(ratio_q);

  logic [NCH-1:0] ch_in, ch_edge, ch_dclk, ch_rise;
  assign ch_in = {fb_in, ref_in};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n(rst_n), .din(ch_in[g]), .rise(ch_edge[g])
    );
    pfd_prescaler u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (armed),
      .half_m1(half_m1),
      .edge_in(ch_edge[g]),
      .dclk   (ch_dclk[g]),
      .rise   (ch_rise[g])
    );
  end

  pfd_core #(.DLY_W(DLY_W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .set_up(ch_rise[0]),
    .set_dn(ch_rise[1]),
    .dly   (rst_dly),
    .up    (up),
    .dn    (dn)
  );

  assign ref_div = ch_dclk[0];
  assign fb_div  = ch_dclk[1];

  assert_ratio_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(ratio_q));
endmodule

// File: tb/pfd_prescaled_tb.sv
module pfd_prescaled_tb;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, fb_in = 1'b0;
  logic [1:0] div_sel = '0;
  logic [2:0] rst_dly = '0;
  logic up, dn, ref_div, fb_div;

  int checks = 0, fails = 0;
  bit done = 0;
  bit gen_en = 0;
  int shift = 0;

  always #5 clk = ~clk;

  pfd_prescaled u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .div_sel(div_sel), .rst_dly(rst_dly),
    .up(up), .dn(dn), .ref_div(ref_div), .fb_div(fb_div)
  );

  // Input waveform generator: equal-period square waves, one delayed.
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      if (gen_en) begin
        int rd, fd;
        rd = (shift < 0) ? -shift : 0;
        fd = (shift > 0) ? shift : 0;
        ref_in = (ph >= rd) && (((ph - rd) % P) < P/2);
        fb_in  = (ph >= fd) && (((ph - fd) % P) < P/2);
        ph++;
      end else begin
        ph = 0;
        ref_in = 1'b0;
        fb_in  = 1'b0;
      end
    end
  end

  // Output monitor, sampled away from the active edge.
  int up_run, dn_run, last_up_w, last_dn_w;
  int rp_cnt, rh_cnt, last_ref_per, last_ref_hi;
  int fp_cnt, last_fb_per;
  logic ref_d, fb_d;
  initial begin
    up_run = 0; dn_run = 0; last_up_w = 0; last_dn_w = 0;
    rp_cnt = 0; rh_cnt = 0; last_ref_per = 0; last_ref_hi = 0;
    fp_cnt = 0; last_fb_per = 0; ref_d = 0; fb_d = 0;
    forever begin
      @(negedge clk);
      if (up) up_run++; else if (up_run != 0) begin last_up_w = up_run; up_run = 0; end
      if (dn) dn_run++; else if (dn_run != 0) begin last_dn_w = dn_run; dn_run = 0; end
      rp_cnt++; fp_cnt++;
      if (ref_div) rh_cnt++;
      if (ref_div && !ref_d) begin last_ref_per = rp_cnt; rp_cnt = 0; end
      if (!ref_div && ref_d) begin last_ref_hi = rh_cnt; rh_cnt = 0; end
      if (fb_div && !fb_d) begin last_fb_per = fp_cnt; fp_cnt = 0; end
      ref_d = ref_div; fb_d = fb_div;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_records();
    last_up_w = 0; last_dn_w = 0; last_ref_per = 0; last_ref_hi = 0; last_fb_per = 0;
  endtask

  task automatic start_run(input int sel, input int d, input int sh);
    gen_en = 0;
    @(negedge clk);
    rst_n = 1'b0;
    div_sel = 2'(sel);
    rst_dly = 3'(d);
    shift = sh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    clear_records();
    gen_en = 1;
  endtask

  initial begin
    // Reset state, R8
    repeat (3) @(negedge clk);
    check("R8 reset up", int'(up), 0);
    check("R8 reset dn", int'(dn), 0);
    check("R8 reset ref_div", int'(ref_div), 0);
    check("R8 reset fb_div", int'(fb_div), 0);

    for (int sel = 0; sel < 4; sel++) begin
      int n;
      n = 2 << sel;
      for (int k = 0; k < 3; k++) begin
        for (int sg = 0; sg < 2; sg++) begin
          if (k == 0 && sg == 1) continue;
          for (int d = 0; d < 8; d++) begin
            int sh, exp_up, exp_dn;
            sh = (sg == 0) ? k : -k;
            start_run(sel, d, sh);
            repeat (3 * n * P + 20) @(negedge clk);
            exp_up = (sh >= 0) ? k + d + 1 : d + 1;
            exp_dn = (sh <= 0) ? k + d + 1 : d + 1;
            if (k == 0) begin
              check("R6 coincident up width", last_up_w, d + 1);
              check("R6 coincident dn width", last_dn_w, d + 1);
            end else begin
              check("R4 R5 up width", last_up_w, exp_up);
              check("R4 R5 dn width", last_dn_w, exp_dn);
            end
            if (k == 0 && d == 0) begin
              check("R1 ref_div period", last_ref_per, n * P);
              check("R1 ref_div high time", last_ref_hi, (n / 2) * P);
              check("R2 fb_div period", last_fb_per, n * P);
              div_sel = 2'((sel + 1) % 4);
              last_ref_per = 0;
              repeat (2 * n * P + 4) @(negedge clk);
              check("R3 ratio held after select change", last_ref_per, n * P);
            end
          end
        end
      end
    end

    // Asynchronous reset mid-run, R8
    start_run(1, 7, 2);
    begin
      bit seen;
      seen = 0;
      for (int i = 0; i < 200 && !seen; i++) begin
        @(negedge clk);
        if (up && ref_div) seen = 1;
      end
      check("R8 up reached before reset", int'(seen), 1);
    end
    #2 rst_n = 1'b0;
    #1;
    check("R8 async up", int'(up), 0);
    check("R8 async dn", int'(dn), 0);
    check("R8 async ref_div", int'(ref_div), 0);
    check("R8 async fb_div", int'(fb_div), 0);
    gen_en = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule